// File: doc/BRIEF.md
# Overwrite-Oldest Message Buffer with Status Flags

This block is a per-channel receive buffer for 32-bit messages arriving from a serial bus. Acceptance logic upstream pushes each accepted message with a write strobe. A host register interface pops messages with a read strobe and sees each popped message on a registered data output.

The buffer never refuses a write. When it already holds its full capacity, the incoming message is stored and the oldest stored message is dropped, so the buffer always keeps the most recent messages.

Three registered status outputs describe the occupancy: not-empty, above-threshold and full. The above-threshold flag compares the occupancy against a programmable level applied on an input. A read on an empty buffer does not change any state and raises a one-cycle underflow pulse.

Top module: `msg_fifo_ovw`

## Requirements
- R1: After reset, `rd_data_o` is 0, `underflow_o` is 0 and all three status flags are 0. The buffer is empty.
- R2: A read strobe on a non-empty buffer pops the oldest stored message onto `rd_data_o` in the cycle after the strobe. Messages leave in the order they were written.
- R3: `not_empty_o` is 1 in the cycle after any cycle that ends with at least one stored message. In particular, it is 1 in the cycle after every write.
- R4: `above_thr_o` is 1 exactly when the occupancy after the cycle is strictly greater than the unsigned value on `thresh_i` at that clock edge.
- R5: `full_o` is 1 exactly when the occupancy after the cycle equals the depth (32). The occupancy never exceeds 32.
- R6: A write without a read while full stores the new message and discards the oldest one. The occupancy stays at 32, so later reads return the newest 32 messages in order.
- R7: A read strobe while empty leaves `rd_data_o`, the pointers and the occupancy unchanged, and sets `underflow_o` to 1 for exactly the next cycle.
- R8: A read and a write in the same cycle on a non-empty buffer leave the occupancy unchanged. When the buffer is full, the oldest message is delivered and the new one is stored, so no message is lost.
- R9: All status flags are registered. Each one reflects the occupancy after the current cycle's read and write have both been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe from the acceptance logic |
| wr_data_i | input | 32 | Message to store |
| rd_en_i | input | 1 | Read strobe from the host interface |
| thresh_i | input | 6 | Programmable threshold level |
| rd_data_o | output | 32 | Last popped message |
| not_empty_o | output | 1 | At least one message is stored |
| above_thr_o | output | 1 | Occupancy is greater than `thresh_i` |
| full_o | output | 1 | Occupancy equals 32 |
| underflow_o | output | 1 | One-cycle pulse after a read on an empty buffer |

## Verification
The following input patterns are applied:

- **Short write-then-drain run:** separates ordering faults from flag-timing faults.
- **Threshold sweep while filling and draining:** exposes off-by-one errors between the strict and non-strict comparison.
- **Writes past capacity followed by a full drain:** shows whether the oldest entries or the newest entries were dropped.
- **Simultaneous read and write at the full, mid-level and empty points:** separates a lost message from a wrong occupancy count.
- **Reads on an empty buffer:** check that the data is held and the underflow pulse appears.
- **Long random mix with changing thresholds:** catches interactions that the directed runs miss.

// File: rtl/msg_fifo_pkg.sv
package msg_fifo_pkg;
  typedef struct packed {
    logic not_empty;
    logic above_thr;
    logic full;
  } mf_status_t;
endpackage

// File: rtl/mf_ctrl.sv
module mf_ctrl #(
  parameter int DEPTH = 32,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             underflow_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic empty, full, drop, uf_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CNT_W'(DEPTH));
  assign push_o = wr_en_i;
  assign pop_o  = rd_en_i && !empty;
  // write into a full buffer with no pop: oldest entry is dropped
  assign drop   = wr_en_i && full && !pop_o;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (push_o && !pop_o && !full) cnt_nxt_o = cnt_q + 1'b1;
    else if (pop_o && !push_o)     cnt_nxt_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      uf_q     <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt_o;
      if (push_o)         wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_o || drop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      uf_q <= rd_en_i && empty;
    end
  end

  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign underflow_o = uf_q;

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r6_full_write_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && wr_en_i && !rd_en_i |=> cnt_q == CNT_W'(DEPTH));
  a_r8_rw_count_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && rd_en_i && !empty |=> $stable(cnt_q));
  a_r7_empty_read_no_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !wr_en_i && empty |=> $stable(rd_ptr_q) && cnt_q == '0);
endmodule

// File: rtl/mf_store.sv
module mf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_i] <= wr_data_i;
  end

  // captures old entry even when the same slot is rewritten this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (pop_i) rd_q <= mem_q[rd_ptr_i];
  end

  assign rd_data_o = rd_q;

  a_r7_hold_without_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(rd_data_o));
endmodule

// File: rtl/mf_flags.sv
module mf_flags
  import msg_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output mf_status_t       status_o
);
  mf_status_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else begin
      st_q.not_empty <= (cnt_nxt_i != '0);
      st_q.above_thr <= (cnt_nxt_i > thresh_i);
      st_q.full      <= (cnt_nxt_i == CNT_W'(DEPTH));
    end
  end

  assign status_o = st_q;

  a_r5_full_implies_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.full |-> st_q.not_empty);
  a_r4_above_implies_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q.above_thr |-> st_q.not_empty);
endmodule

// File: rtl/msg_fifo_ovw.sv
module msg_fifo_ovw
  import msg_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  thresh_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              not_empty_o,
  output logic              above_thr_o,
  output logic              full_o,
  output logic              underflow_o
);
  logic             push, pop;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_nxt;
  mf_status_t       status;

  mf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .push_o      (push),
    .pop_o       (pop),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .cnt_nxt_o   (cnt_nxt),
    .underflow_o (underflow_o)
  );

  mf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .wr_ptr_i  (wr_ptr),
    .wr_data_i (wr_data_i),
    .pop_i     (pop),
    .rd_ptr_i  (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  mf_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_i (cnt_nxt),
    .thresh_i  (thresh_i),
    .status_o  (status)
  );

  assign not_empty_o = status.not_empty;
  assign above_thr_o = status.above_thr;
  assign full_o      = status.full;

  a_r3_write_sets_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> not_empty_o);
  a_r7_underflow_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> $stable(rd_data_o));
endmodule

// File: tb/sim_msg_fifo_ovw.sv
module sim_msg_fifo_ovw;
  localparam int DW    = 32;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] thr = '0;
  logic [DW-1:0] rd_data;
  logic          ne, above, full, uf;

  always #10 clk = ~clk;

  msg_fifo_ovw #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .thresh_i(thr), .rd_data_o(rd_data),
    .not_empty_o(ne), .above_thr_o(above), .full_o(full), .underflow_o(uf)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] exp_data = '0;
  logic          exp_uf = 1'b0;
  logic [DW-1:0] seq = 32'h1000_0000;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare(input string ph);
    chk({ph, " R2 data"},      rd_data, exp_data);
    chk({ph, " R3 not_empty"}, DW'(ne),    DW'(q.size() > 0));
    chk({ph, " R4 above_thr"}, DW'(above), DW'(q.size() > int'(thr)));
    chk({ph, " R5 full"},      DW'(full),  DW'(q.size() == DEPTH));
    chk({ph, " R7 underflow"}, DW'(uf),    DW'(exp_uf));
  endtask

  // reference model: pop first, then push, then trim to the newest DEPTH
  task automatic step(input logic w, input logic r, input string ph);
    logic [DW-1:0] d;
    d = seq;
    seq = seq + 1;
    wr_en = w; wr_data = d; rd_en = r;
    exp_uf = r && (q.size() == 0);
    if (r && q.size() > 0) exp_data = q.pop_front();
    if (w) begin
      q.push_back(d);
      if (q.size() > DEPTH) void'(q.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    compare(ph);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1 in-reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after-release");

    // R2/R3: short write then drain
    thr = CW'(40);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R3 write");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R2 drain");

    // R4/R9: threshold sweep, flags after the same cycle's update
    thr = CW'(3);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, "R4 fill");
    thr = CW'(5);
    step(1'b0, 1'b0, "R4 thr-change");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R9 drain");
    thr = CW'(0);
    step(1'b1, 1'b0, "R4 thr0");
    step(1'b0, 1'b1, "R4 thr0-drain");

    // R5/R6: fill past capacity, then drain and see the newest 32
    thr = CW'(31);
    for (int i = 0; i < DEPTH + 5; i++) step(1'b1, 1'b0, "R6 overfill");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R6 drain");

    // R7: reads on empty
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7 empty-read");
    step(1'b1, 1'b1, "R7 empty-read-with-write");
    step(1'b0, 1'b1, "R7 drain");

    // R8: simultaneous read and write at full, mid level and empty
    for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, "R8 fill");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, "R8 full-rw");
    for (int i = 0; i < DEPTH / 2; i++) step(1'b0, 1'b1, "R8 half-drain");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R8 mid-rw");
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, "R8 drain");

    // random mix
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) thr = CW'($urandom_range(0, DEPTH));
      step(1'($urandom_range(0, 99) < 55), 1'($urandom_range(0, 99) < 45), "R9 random");
    end

    summary();
    $finish;
  end
endmodule